// File: doc/BRIEF.md
# Three-Bit Compare State Encoder with Condition Evaluator

This block takes two N-bit operands and classifies their difference (A minus B) into one of seven joint states. A state records, all at once, the unsigned ordering, the signed ordering and whether the signed subtraction overflowed. The state is kept in a 3-bit register, not as four separate zero, sign, carry and overflow flags. A 4-bit condition selector then asks whether the stored state satisfies one of fourteen arithmetic conditions, or the constant conditions always and never. The answer comes back on a single output.

A compare is taken on any cycle in which `cmp_valid` is high. The block has no back-pressure: it never stalls, so there is no ready signal and every strobe is accepted at once. The operands that are present on that clock edge replace the stored state. The selector is a plain control input, and `cond_true` follows it combinationally from the register. Software or a sequencer can therefore sweep the selector over many cycles to read out every condition of one compare.

State codes: 0 = below both unsigned and signed; 1 = unsigned below, signed above, no overflow; 2 = unsigned below, signed above, overflow; 3 = unsigned above, signed below, no overflow; 4 = unsigned above, signed below, overflow; 5 = above both ways; 6 = equal; 7 = never produced.

Top module: `cmp_state_unit`

## Requirements
- R1: After synchronous reset the stored state is "equal" (6). Selectors EQ, UGE, ULE, SGE, SLE, NOV, NNEG and ALWAYS read true, and all others read false.
- R2: The state register loads only on a rising edge where `cmp_valid` is 1. When `cmp_valid` is 0, changing the operands leaves every condition result unchanged.
- R3: Selector 0 (EQ) is true exactly when A equals B, and selector 1 (NE) is its complement.
- R4: Selectors 2 (ULT), 3 (UGE), 4 (ULE) and 5 (UGT) give the unsigned orderings of A against B.
- R5: Selectors 6 (SLT), 7 (SGE), 8 (SLE) and 9 (SGT) give the two's-complement orderings of A against B.
- R6: Selector 10 (OV) is true when A minus B overflows the signed N-bit range, and selector 11 (NOV) is its complement.
- R7: Selector 12 (NEG) equals the top bit of the N-bit difference A minus B, and selector 13 (NNEG) is its complement.
- R8: Selector 14 (ALWAYS) reads 1 and selector 15 (NEVER) reads 0 for every state.
- R9: `cond_true` responds to the selector in the same cycle. It reflects a compare from the cycle after that compare's strobe edge. During the strobe cycle itself it still shows the previous compare.
- R10: After each compare, exactly one of EQ, ULT and UGT is true, and exactly one of EQ, SLT and SGT is true. The register never holds code 7; if it did, every selector except ALWAYS would read false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Compare strobe; loads the state on this edge |
| op_a | input | W | Operand A (minuend) |
| op_b | input | W | Operand B (subtrahend) |
| cond_sel | input | 4 | Condition selector, codes 0 to 15 |
| cond_true | output | 1 | Selected condition holds for the stored state |

## Verification
Two things can happen in the same cycle: a new compare is strobed in, and the evaluator is read with the selector. The bench provokes this by driving new operands with `cmp_valid` high and, in that same cycle, sampling `cond_true` before the edge. The result must still match the previous compare. One cycle later it must match the new operands. A behavioural model holds the last accepted operand pair as integers. From that pair it computes signed and unsigned relations, overflow and the sign of the difference, and it compares them on every cycle across corner pairs and random pairs.

// File: rtl/cmp_state_pkg.sv
package cmp_state_pkg;

  typedef enum logic [2:0] {
    ST_BOTH_LT    = 3'd0,
    ST_ULT_SGT    = 3'd1,
    ST_ULT_SGT_OV = 3'd2,
    ST_UGT_SLT    = 3'd3,
    ST_UGT_SLT_OV = 3'd4,
    ST_BOTH_GT    = 3'd5,
    ST_EQUAL      = 3'd6,
    ST_UNUSED     = 3'd7
  } cmp_state_e;

  typedef enum logic [3:0] {
    C_EQ, C_NE, C_ULT, C_UGE, C_ULE, C_UGT, C_SLT, C_SGE,
    C_SLE, C_SGT, C_OV, C_NOV, C_NEG, C_NNEG, C_ALW, C_NEV
  } cond_sel_e;

  localparam int SEL_W    = 4;
  localparam int NUM_COND = 1 << SEL_W;
  localparam int NUM_PAIR = NUM_COND / 2;

endpackage

// File: rtl/cmp_state_encode.sv
module cmp_state_encode
  import cmp_state_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output cmp_state_e   st_next
);
  localparam int MSB = W - 1;

  logic [W-1:0] diff;
  logic         is_eq, u_lt, s_lt, ovf;

  always_comb begin
    diff  = op_a - op_b;
    is_eq = (op_a == op_b);
    u_lt  = (op_a < op_b);
    s_lt  = ($signed(op_a) < $signed(op_b));
    ovf   = (op_a[MSB] != op_b[MSB]) && (diff[MSB] != op_a[MSB]);
  end

  always_comb begin
    if (is_eq)              st_next = ST_EQUAL;
    else if (u_lt && s_lt)  st_next = ST_BOTH_LT;
    else if (u_lt)          st_next = ovf ? ST_ULT_SGT_OV : ST_ULT_SGT;
    else if (s_lt)          st_next = ovf ? ST_UGT_SLT_OV : ST_UGT_SLT;
    else                    st_next = ST_BOTH_GT;
  end

endmodule

// File: rtl/cmp_state_reg.sv
module cmp_state_reg
  import cmp_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  cmp_state_e st_next,
  output cmp_state_e st_q
);

  always_ff @(posedge clk) begin
    if (rst)       st_q <= ST_EQUAL;
    else if (load) st_q <= st_next;
  end

  // R2: without a strobe the state holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(st_q));

  // R2: a strobe captures the encoder's verdict
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> (st_q == $past(st_next)));

  // R10: code 7 never appears
  a_r10_state_valid: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (st_q != ST_UNUSED));

endmodule

// File: rtl/cmp_cond_eval.sv
module cmp_cond_eval
  import cmp_state_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cmp_state_e       st,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);

  logic                valid;
  logic [NUM_PAIR-1:0] base;
  logic [NUM_COND-1:0] cond_vec;

  always_comb begin
    valid   = (st != ST_UNUSED);
    base[0] = (st == ST_EQUAL);
    base[1] = (st == ST_BOTH_LT) || (st == ST_ULT_SGT) || (st == ST_ULT_SGT_OV);
    base[2] = base[1] || base[0];
    base[3] = (st == ST_BOTH_LT) || (st == ST_UGT_SLT) || (st == ST_UGT_SLT_OV);
    base[4] = base[3] || base[0];
    base[5] = (st == ST_ULT_SGT_OV) || (st == ST_UGT_SLT_OV);
    base[6] = (st == ST_BOTH_LT) || (st == ST_ULT_SGT_OV) || (st == ST_UGT_SLT);
    base[7] = 1'b1;
  end

  // even code = base condition, odd code = its complement (valid states only)
  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    if (k == 2 || k == 4) begin : g_swap
      // ULE/UGT and SLE/SGT: the "or-equal" form sits at the even code
      assign cond_vec[2*k]   = base[k];
      assign cond_vec[2*k+1] = valid & ~base[k];
    end else begin : g_plain
      assign cond_vec[2*k]   = base[k];
      assign cond_vec[2*k+1] = valid & ~base[k];
    end
  end

  assign hit = cond_vec[sel];

  // R4: unsigned trichotomy
  a_r4_unsigned_one: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($countones({cond_vec[C_EQ], cond_vec[C_ULT], cond_vec[C_UGT]}) == 1));

  // R5: signed trichotomy
  a_r5_signed_one: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($countones({cond_vec[C_EQ], cond_vec[C_SLT], cond_vec[C_SGT]}) == 1));

  // R6: overflow pair complementary
  a_r6_ov_pair: assert property (@(posedge clk) disable iff (rst)
    valid |-> (cond_vec[C_OV] != cond_vec[C_NOV]));

  // R7: an overflowing compare has sign opposite to signed ordering
  a_r7_neg_consistent: assert property (@(posedge clk) disable iff (rst)
    (valid && !cond_vec[C_EQ]) |->
      (cond_vec[C_NEG] == (cond_vec[C_SLT] ^ cond_vec[C_OV])));

  // R8: constant conditions
  a_r8_constants: assert property (@(posedge clk) disable iff (rst)
    cond_vec[C_ALW] && !cond_vec[C_NEV]);

endmodule

// File: rtl/cmp_state_unit.sv
module cmp_state_unit
  import cmp_state_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   cond_sel,
  output logic         cond_true
);

  cmp_state_e st_next, st_q;

  cmp_state_encode #(.W(W)) u_enc (
    .op_a    (op_a),
    .op_b    (op_b),
    .st_next (st_next)
  );

  cmp_state_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (cmp_valid),
    .st_next (st_next),
    .st_q    (st_q)
  );

  cmp_cond_eval u_eval (
    .clk (clk),
    .rst (rst),
    .st  (st_q),
    .sel (cond_sel),
    .hit (cond_true)
  );

endmodule

// File: tb/cmp_state_unit_tb.sv
module cmp_state_unit_tb_top;
  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         cmp_valid;
  logic [W-1:0] op_a, op_b;
  logic [3:0]   cond_sel;
  logic         cond_true;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [W-1:0] ha, hb;   // last accepted operands (model state)

  always #(PERIOD/2) clk = ~clk;

  cmp_state_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid),
    .op_a(op_a), .op_b(op_b), .cond_sel(cond_sel), .cond_true(cond_true)
  );

  function automatic bit ref_cond(logic [W-1:0] a, logic [W-1:0] b, int s);
    int ua, ub, sa, sb, sd;
    logic [W-1:0] d;
    bit ov, neg;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    sd = sa - sb;
    ov = (sd > (2**(W-1) - 1)) || (sd < -(2**(W-1)));
    d  = a - b;
    neg = d[W-1];
    case (s)
      0:  return ua == ub;
      1:  return ua != ub;
      2:  return ua <  ub;
      3:  return ua >= ub;
      4:  return ua <= ub;
      5:  return ua >  ub;
      6:  return sa <  sb;
      7:  return sa >= sb;
      8:  return sa <= sb;
      9:  return sa >  sb;
      10: return ov;
      11: return !ov;
      12: return neg;
      13: return !neg;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string sel_tag(int s);
    if (s < 2)  return "R3";
    if (s < 6)  return "R4";
    if (s < 10) return "R5";
    if (s < 12) return "R6";
    if (s < 14) return "R7";
    return "R8";
  endfunction

  task automatic check(bit act, bit exp, string tag, int s);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d a=%h b=%h actual=%b expected=%b", tag, s, ha, hb, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check before the edge, update model after it
  task automatic cycle(logic [W-1:0] a, logic [W-1:0] b, bit v, int s, string tag);
    @(negedge clk);
    op_a = a; op_b = b; cmp_valid = v; cond_sel = 4'(s);
    #1;
    check(cond_true, ref_cond(ha, hb, s), tag, s);
    @(posedge clk);
    if (v) begin ha = a; hb = b; end
  endtask

  // Strobe a compare, then sweep all selectors; R10 exclusivity on the side
  task automatic compare_and_sweep(logic [W-1:0] a, logic [W-1:0] b);
    bit r[16];
    // R9: in the strobe cycle the old compare is still visible
    cycle(a, b, 1'b1, 0, "R9");
    for (int s = 0; s < 16; s++) begin
      cycle(~a, b, 1'b0, s, (s == 0) ? "R9" : sel_tag(s));
      r[s] = cond_true;
    end
    n_checks++;
    if ((int'(r[0]) + int'(r[2]) + int'(r[5]) != 1) ||
        (int'(r[0]) + int'(r[6]) + int'(r[9]) != 1)) begin
      n_fail++;
      $display("FAIL R10 a=%h b=%h actual eq=%b ult=%b ugt=%b slt=%b sgt=%b expected one-hot",
               a, b, r[0], r[2], r[5], r[6], r[9]);
    end
  endtask

  initial begin
    logic [W-1:0] corners [8];
    rst = 1'b1; cmp_valid = 1'b0; op_a = '0; op_b = '0; cond_sel = '0;
    ha = '0; hb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state reads as equal
    for (int s = 0; s < 16; s++) cycle(8'h5A, 8'h13, 1'b0, s, "R1");

    corners[0] = 8'h00; corners[1] = 8'h01; corners[2] = 8'h7F; corners[3] = 8'h80;
    corners[4] = 8'h81; corners[5] = 8'hFF; corners[6] = 8'h40; corners[7] = 8'hC0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        compare_and_sweep(corners[i], corners[j]);

    // R2: operands change without strobe; results must reflect held pair
    compare_and_sweep(8'h10, 8'h20);
    for (int s = 0; s < 16; s++) cycle(8'hF0, 8'h01, 1'b0, s, "R2");

    for (int n = 0; n < 200; n++)
      compare_and_sweep(W'($urandom), W'($urandom));

    // R9: back-to-back strobes, each read in its own and the following cycle
    cycle(8'h03, 8'h03, 1'b1, 0, "R9");
    cycle(8'h90, 8'h10, 1'b1, 0, "R9");
    cycle(8'h10, 8'h90, 1'b1, 6, "R9");
    cycle(8'h10, 8'h90, 1'b0, 6, "R9");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule